// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a read-only cache of 4 KB that sits between a requester and a slower word-addressed memory. The storage is 512 sets of two ways, and each way holds one 32-bit word with its tag and a valid flag. A request carries a 32-bit byte address. The cache reads both ways of the addressed set in the same cycle, compares both stored tags against the address, and returns either the word that matched or, on a miss, the word fetched from memory. The fetched word is then installed in the set.

A miss installs into an empty way first, taking the lower-numbered empty way. Once both ways are valid, a single recency bit per set picks the replacement. This policy gives a different hit/miss pattern from a direct-mapped cache of the same size. A cache of that kind keeps only one word per set and so keeps evicting blocks whose addresses share a set. While a miss is outstanding, the cache accepts no new request. Two event counters record how many lookups hit and how many missed.

Top module: `twoway_cache`

## Requirements
- R1: The byte address is split into a tag in bits 31..11, a set number in bits 10..2 and a byte offset in bits 1..0. The offset has no effect on the lookup or on the returned word. For example, addresses 3 and 16386 hit on the words that hold 0 and 16384.
- R2: After a synchronous reset the cache is empty, so the first access to any address misses. After reset `reqReady` is 1, `rspValid` and `memReqValid` are 0, and both counters are 0.
- R3: A lookup hits when either way of the addressed set is valid and holds the address tag. The returned word comes from the way that matched. A valid way with a different tag in the same set, such as address 2048 (tag 1) against address 0 (tag 0), does not hit.
- R4: On a miss, `memReqValid` rises in the cycle after the request is accepted. It carries the word-aligned address (bits 1..0 zero) and stays high with `reqReady` low until a cycle in which `memRspValid` is high.
- R5: A miss fills way 0 when way 0 of the set is invalid. Otherwise it fills way 1 when way 1 is invalid.
- R6: When both ways are valid, a miss replaces the way that was not the most recently used. Every hit and every fill counts as a use.
- R7: A hit completes in the cycle after acceptance, with `rspValid`=1 and `rspHit`=1. A miss completes in the cycle after `memRspValid`, with `rspValid`=1, `rspHit`=0 and `rspData` equal to the word memory returned.
- R8: `hitCount` increments once for each accepted request that hits, and `missCount` increments once for each accepted request that misses.
- R9: From an empty cache, the byte addresses 0, 4, 8188, 0, 16384, 0 give miss, miss, miss, hit, miss, hit. That leaves the counters at 2 hits and 4 misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Lookup request |
| reqAddr | input | 32 | Byte address of the request |
| reqReady | output | 1 | High when a request can be accepted |
| rspValid | output | 1 | One-cycle pulse when an access completes |
| rspHit | output | 1 | The completed access hit in the cache |
| rspData | output | 32 | Word returned for the completed access |
| memReqValid | output | 1 | Read request to backing memory, held until answered |
| memReqAddr | output | 32 | Word-aligned byte address of the memory read |
| memRspValid | input | 1 | Memory read data is valid |
| memRspData | input | 32 | Memory read data |
| hitCount | output | 16 | Number of lookups that hit |
| missCount | output | 16 | Number of lookups that missed |

## Verification
The assertions watch the cycle-level contract on every clock. At most one way matches. The empty-way fill choice follows the valid bits of the set. Hit and fill completions arrive exactly one cycle after their trigger, carrying the right hit flag and the memory word. The memory request stays up until it is answered, and the hit counter steps once per hit. Only the bench's address sequences can show that the recency bit picks the correct victim across a chain of hits and fills, that the six-access trace yields its exact pattern and totals, that the byte offset is ignored, and that reset empties a cache that was populated.

// File: rtl/cache2w_pkg.sv
`timescale 1ns/1ps
package cache2w_pkg;
  // Strobes from the control to the datapath; at most one is high per cycle.
  typedef struct packed {
    logic hitUpd;   // accepted lookup that hit
    logic missCap;  // accepted lookup that missed: capture address and victim
    logic fillWr;   // memory answered: install word and complete
  } ctrlStrobes_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } ctrlState_t;
endpackage

// File: rtl/cache2w_ctrl.sv
`timescale 1ns/1ps
module cache2w_ctrl
  import cache2w_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         reqValid,
  input  logic         lookupHit,
  input  logic         memRspValid,
  output logic         reqReady,
  output logic         memReqValid,
  output ctrlStrobes_t strobes
);

  ctrlState_t stateQ;

  assign reqReady    = (stateQ == ST_IDLE);
  assign memReqValid = (stateQ == ST_FILL);

  always_comb begin
    strobes         = '0;
    strobes.hitUpd  = reqReady && reqValid && lookupHit;
    strobes.missCap = reqReady && reqValid && !lookupHit;
    strobes.fillWr  = memReqValid && memRspValid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
    end else begin
      unique case (stateQ)
        ST_IDLE: if (strobes.missCap) stateQ <= ST_FILL;
        ST_FILL: if (memRspValid)     stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  AST_HOLD_MEM_REQ: assert property (@(posedge clk) disable iff (rst)
    memReqValid && !memRspValid |=> memReqValid); // R4

  AST_MISS_STARTS_FILL: assert property (@(posedge clk) disable iff (rst)
    strobes.missCap |=> memReqValid && !reqReady); // R4

endmodule

// File: rtl/cache2w_datapath.sv
`timescale 1ns/1ps
module cache2w_datapath
  import cache2w_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WORD_W   = 32,
  parameter int OFFSET_W = 2,
  parameter int INDEX_W  = 9,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] memRspData,
  output logic              lookupHit,
  output logic              rspValid,
  output logic              rspHit,
  output logic [WORD_W-1:0] rspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);

  localparam int WAYS  = 2;
  localparam int TAG_W = ADDR_W - INDEX_W - OFFSET_W;
  localparam int SETS  = 1 << INDEX_W;
  localparam int LINE_W = ADDR_W - OFFSET_W;

  // Address fields of the incoming lookup.
  logic [TAG_W-1:0]    lookupTag;
  logic [INDEX_W-1:0]  lookupIdx;
  logic [OFFSET_W-1:0] unusedOffsetBits;

  assign lookupTag        = reqAddr[ADDR_W-1 -: TAG_W];
  assign lookupIdx        = reqAddr[OFFSET_W +: INDEX_W];
  assign unusedOffsetBits = reqAddr[OFFSET_W-1:0];

  // Captured miss: line address and the way chosen to receive it.
  logic [LINE_W-1:0]  lineQ;
  logic               victimQ;
  logic [TAG_W-1:0]   fillTag;
  logic [INDEX_W-1:0] fillIdx;

  assign fillTag    = lineQ[LINE_W-1 -: TAG_W];
  assign fillIdx    = lineQ[INDEX_W-1:0];
  assign memReqAddr = {lineQ, {OFFSET_W{1'b0}}};

  // Per-way read of the addressed set.
  logic [WAYS-1:0]   rdValid;
  logic [TAG_W-1:0]  rdTag  [WAYS];
  logic [WORD_W-1:0] rdData [WAYS];
  logic [WAYS-1:0]   wayMatch;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]   validQ;
    logic [TAG_W-1:0]  tagQ  [SETS];
    logic [WORD_W-1:0] dataQ [SETS];
    logic              wayWr;

    assign wayWr      = strobes.fillWr && (victimQ == 1'(w));
    assign rdValid[w] = validQ[lookupIdx];
    assign rdTag[w]   = tagQ[lookupIdx];
    assign rdData[w]  = dataQ[lookupIdx];
    assign wayMatch[w] = rdValid[w] && (rdTag[w] == lookupTag);

    always_ff @(posedge clk) begin
      if (rst) begin
        validQ <= '0;
      end else if (wayWr) begin
        validQ[fillIdx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wayWr) begin
        tagQ[fillIdx]  <= fillTag;
        dataQ[fillIdx] <= memRspData;
      end
    end
  end

  // Hit is the OR of the valid-qualified matches; the match picks the word.
  logic              hitWay;
  logic [WORD_W-1:0] hitWord;

  assign lookupHit = |wayMatch;
  assign hitWay    = wayMatch[1];
  assign hitWord   = hitWay ? rdData[1] : rdData[0];

  // Victim: lowest empty way, else the way the recency bit names.
  logic [SETS-1:0] lruQ;
  logic            victimSel;

  always_comb begin
    if (!rdValid[0])      victimSel = 1'b0;
    else if (!rdValid[1]) victimSel = 1'b1;
    else                  victimSel = lruQ[lookupIdx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lruQ <= '0;
    end else if (strobes.hitUpd) begin
      lruQ[lookupIdx] <= ~hitWay;
    end else if (strobes.fillWr) begin
      lruQ[fillIdx] <= ~victimQ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lineQ   <= '0;
      victimQ <= 1'b0;
    end else if (strobes.missCap) begin
      lineQ   <= reqAddr[ADDR_W-1:OFFSET_W];
      victimQ <= victimSel;
    end
  end

  // Completion and event counting.
  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid  <= 1'b0;
      rspHit    <= 1'b0;
      rspData   <= '0;
      hitCount  <= '0;
      missCount <= '0;
    end else begin
      rspValid <= strobes.hitUpd || strobes.fillWr;
      if (strobes.hitUpd) begin
        rspHit   <= 1'b1;
        rspData  <= hitWord;
        hitCount <= hitCount + CNT_W'(1);
      end else if (strobes.fillWr) begin
        rspHit  <= 1'b0;
        rspData <= memRspData;
      end
      if (strobes.missCap) missCount <= missCount + CNT_W'(1);
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    (strobes.hitUpd || strobes.missCap) |-> $onehot0(wayMatch)); // R3

  AST_FILL_WAY0_FIRST: assert property (@(posedge clk) disable iff (rst)
    strobes.missCap && !rdValid[0] |=> victimQ == 1'b0); // R5

  AST_FILL_WAY1_NEXT: assert property (@(posedge clk) disable iff (rst)
    strobes.missCap && rdValid[0] && !rdValid[1] |=> victimQ == 1'b1); // R5

  AST_HIT_COMPLETES: assert property (@(posedge clk) disable iff (rst)
    strobes.hitUpd |=> rspValid && rspHit); // R7

  AST_FILL_COMPLETES: assert property (@(posedge clk) disable iff (rst)
    strobes.fillWr |=> rspValid && !rspHit && (rspData == $past(memRspData))); // R7

  AST_HIT_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    strobes.hitUpd |=> hitCount == $past(hitCount) + CNT_W'(1)); // R8

endmodule

// File: rtl/twoway_cache.sv
`timescale 1ns/1ps
module twoway_cache
  import cache2w_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WORD_W   = 32,
  parameter int OFFSET_W = 2,
  parameter int INDEX_W  = 9,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              rspValid,
  output logic              rspHit,
  output logic [WORD_W-1:0] rspData,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [WORD_W-1:0] memRspData,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);

  ctrlStrobes_t strobes;
  logic         lookupHit;

  cache2w_ctrl i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .reqValid    (reqValid),
    .lookupHit   (lookupHit),
    .memRspValid (memRspValid),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .strobes     (strobes)
  );

  cache2w_datapath #(
    .ADDR_W   (ADDR_W),
    .WORD_W   (WORD_W),
    .OFFSET_W (OFFSET_W),
    .INDEX_W  (INDEX_W),
    .CNT_W    (CNT_W)
  ) i_datapath (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .reqAddr    (reqAddr),
    .memRspData (memRspData),
    .lookupHit  (lookupHit),
    .rspValid   (rspValid),
    .rspHit     (rspHit),
    .rspData    (rspData),
    .memReqAddr (memReqAddr),
    .hitCount   (hitCount),
    .missCount  (missCount)
  );

endmodule

// File: tb/test_twoway_cache.sv
`timescale 1ns/1ps
module test_twoway_cache;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqReady;
  logic        rspValid;
  logic        rspHit;
  logic [31:0] rspData;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic [15:0] hitCount;
  logic [15:0] missCount;

  always #2.5 clk = ~clk;  // 200 MHz

  twoway_cache i_twoway_cache (
    .clk, .rst, .reqValid, .reqAddr, .reqReady, .rspValid, .rspHit, .rspData,
    .memReqValid, .memReqAddr, .memRspValid, .memRspData, .hitCount, .missCount
  );

  int checks = 0;
  int errors = 0;
  int expHits = 0;
  int expMisses = 0;

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A3C_96E1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doAccess(input logic [31:0] a, input logic expHit, input string req);
    logic gotHit;
    @(negedge clk);
    check(reqReady == 1'b1, "R4", "ready before request", 32'(reqReady), 32'd1);
    reqValid = 1'b1;
    reqAddr  = a;
    @(posedge clk); #1;
    reqValid = 1'b0;
    gotHit = rspValid && rspHit;
    check(gotHit == expHit, req, $sformatf("hit flag for address %0d", a),
          32'(gotHit), 32'(expHit));
    if (expHit) expHits++; else expMisses++;
    if (gotHit) begin
      check(rspData == memWord(a), "R3", "hit word", rspData, memWord(a));
    end else begin
      check(memReqValid && memReqAddr == {a[31:2], 2'b00}, "R4", "memory request address",
            memReqAddr, {a[31:2], 2'b00});
      repeat (2) @(posedge clk);
      #1;
      check(memReqValid && !reqReady && !rspValid, "R4", "request held while waiting",
            {29'd0, memReqValid, reqReady, rspValid}, 32'b100);
      @(negedge clk);
      memRspValid = 1'b1;
      memRspData  = memWord(a);
      @(posedge clk); #1;
      memRspValid = 1'b0;
      check(rspValid && !rspHit, "R7", "miss completion flags",
            {30'd0, rspValid, rspHit}, 32'b10);
      check(rspData == memWord(a), "R7", "miss completion word", rspData, memWord(a));
    end
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic        hit;
    logic [1:0]  grp;  // 0: trace R9, 1: recency R6, 2: offset R1, 3: tag compare R3
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    '{32'd0,     1'b0, 2'd0}, '{32'd4,     1'b0, 2'd0}, '{32'd8188,  1'b0, 2'd0},
    '{32'd0,     1'b1, 2'd0}, '{32'd16384, 1'b0, 2'd0}, '{32'd0,     1'b1, 2'd0},
    '{32'd16384, 1'b1, 2'd1}, '{32'd32768, 1'b0, 2'd1}, '{32'd16384, 1'b1, 2'd1},
    '{32'd0,     1'b0, 2'd1}, '{32'd16384, 1'b1, 2'd1}, '{32'd32768, 1'b0, 2'd1},
    '{32'd0,     1'b0, 2'd1}, '{32'd16384, 1'b0, 2'd1},
    '{32'd3,     1'b1, 2'd2}, '{32'd8191,  1'b1, 2'd2}, '{32'd16386, 1'b1, 2'd2},
    '{32'd2048,  1'b0, 2'd3}, '{32'd0,     1'b0, 2'd3}, '{32'd2048,  1'b1, 2'd3},
    '{32'd4,     1'b1, 2'd3}
  };

  function automatic string grpReq(input logic [1:0] g);
    case (g)
      2'd0:    return "R9";
      2'd1:    return "R6";
      2'd2:    return "R1";
      default: return "R3";
    endcase
  endfunction

  task automatic resetAndCheck(input string what);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    check(reqReady && !rspValid && !memReqValid, "R2", {what, " control outputs"},
          {29'd0, reqReady, rspValid, memReqValid}, 32'b100);
    check(hitCount == 16'd0 && missCount == 16'd0, "R2", {what, " counters"},
          {hitCount, missCount}, 32'd0);
    expHits = 0;
    expMisses = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    resetAndCheck("initial reset");

    for (int i = 0; i < NVEC; i++) begin
      doAccess(VECS[i].addr, VECS[i].hit, grpReq(VECS[i].grp));
      if (i == 5) begin
        // R9: totals after the six-access trace
        check(hitCount == 16'd2 && missCount == 16'd4, "R9", "trace totals",
              {hitCount, missCount}, {16'd2, 16'd4});
      end
    end

    // R8: counters match the number of expected hits and misses
    check(hitCount == 16'(expHits), "R8", "hit counter", 32'(hitCount), 32'(expHits));
    check(missCount == 16'(expMisses), "R8", "miss counter", 32'(missCount), 32'(expMisses));

    // R2: reset of a populated cache empties it
    resetAndCheck("reset after traffic");
    doAccess(32'd0, 1'b0, "R2");
    doAccess(32'd8188, 1'b0, "R2");
    doAccess(32'd0, 1'b1, "R5");
    check(hitCount == 16'd1 && missCount == 16'd2, "R8", "counters after reset",
          {hitCount, missCount}, {16'd1, 16'd2});

    // R7: response is a single-cycle pulse
    @(posedge clk); #1;
    check(rspValid == 1'b0, "R7", "response pulse ends", 32'(rspValid), 32'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule